// File: doc/BRIEF.md
# Pixel Color Lookup with Direct-Color Bypass

This block turns each incoming pixel into a 30-bit output color made of three 10-bit channels. Every clock one pixel arrives, along with a select bit. When the select asks for lookup, the low eight bits of the pixel index a 256-entry palette whose entries are 30 bits wide. Because the entries are wider than the 24-bit input, the palette can hold gamma-corrected or calibrated values. When the select asks for direct color, the three 8-bit input channels are widened to 10 bits and sent straight to the output. This lets a live video window sit over a palette-driven graphics background. The select is honoured independently on every pixel.

A narrow host port loads the palette and reads it back. The host first loads an entry pointer. It then presents the red, green and blue values in that order. The entry is committed only when the blue value is written. Reads step through the channels in the same order. After each complete entry the pointer advances by one, wrapping from the top entry back to zero.

Top module: `pal_lookup`

## Requirements
- R1: While `rst_n` is low, `color_out` and `host_rdata` are zero, the entry pointer is zero and the channel sequence restarts at red.
- R2: With `pix_direct` low, `color_out` on the next clock equals the palette entry indexed by `pix_in[7:0]`. The entry is laid out red in `[29:20]`, green in `[19:10]` and blue in `[9:0]`.
- R3: With `pix_direct` high, `color_out` on the next clock is the input widened per channel. The input has red in `pix_in[23:16]`, green in `[15:8]` and blue in `[7:0]`. Each 8-bit value c becomes the 10-bit value {c, c[7:6]}.
- R4: The path choice follows `pix_direct` of each individual pixel, so alternating the select every clock alternates the output source every clock.
- R5: `host_wr` stores `host_wdata[9:0]` as red, then green, then blue. The palette entry is unchanged after the red and green writes and takes all three values on the clock of the blue write.
- R6: After the blue write or the blue read of an entry, the pointer advances by one, and from 255 it wraps to 0.
- R7: `host_rd` places the current channel (red, then green, then blue) of the entry at the pointer on `host_rdata` one clock later. `host_rdata` holds its value on clocks without a read.
- R8: When a blue write commits an entry in the same clock that a lookup pixel indexes that entry, the output for that pixel shows the old contents. The following lookup shows the new contents.
- R9: `host_addr_we` loads `host_wdata[7:0]` into the pointer and restarts the channel sequence at red. It takes priority over `host_wr` and `host_rd`, and `host_wr` takes priority over `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0]; [7:0] is the palette index |
| pix_direct | input | 1 | 1 = direct-color path, 0 = palette lookup |
| host_addr_we | input | 1 | Load entry pointer from host_wdata[7:0] |
| host_wr | input | 1 | Write one channel value |
| host_rd | input | 1 | Read one channel value |
| host_wdata | input | 10 | Host write data |
| color_out | output | 30 | Output color: red [29:20], green [19:10], blue [9:0] |
| host_rdata | output | 10 | Host read data |

## Verification
Both pixel paths are due exactly one clock after the pixel is presented, and a host read is due one clock after the strobe. Palette writes take effect for lookups presented on the clock after the blue write. The bench drives inputs on the falling edge. At each rising edge a behavioural model computes the expected color and read data, using the palette contents from before any write in that edge. Both outputs are then compared at the next falling edge, half a period after they settle. The collision case and the partial-write case depend on this ordering, so each has a directed sequence of its own.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int IN_W  = 8;
  localparam int CH_W  = 10;
  localparam int DEPTH = 256;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 30,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_data,
  input  logic [AW-1:0] host_addr,
  output logic [DW-1:0] host_data
);
  logic [DW-1:0] mem [DEPTH];

  // storage is not reset; contents are defined by host writes
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign pix_data  = mem[pix_addr];
  assign host_data = mem[host_addr];
endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
  import pal_pkg::*;
#(
  parameter int CH_W = 10,
  parameter int AW   = 8,
  localparam int DW  = 3 * CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_we,
  input  logic            wr,
  input  logic            rd,
  input  logic [CH_W-1:0] wdata,
  input  logic [DW-1:0]   cur_entry,
  output logic [AW-1:0]   addr_q,
  output chan_e           chan_q,
  output logic            commit,
  output logic [DW-1:0]   commit_data,
  output logic [CH_W-1:0] rdata
);
  logic [AW-1:0]   addr_d;
  chan_e           chan_d;
  logic            seq_en;
  logic [CH_W-1:0] stg_r_q, stg_g_q;
  logic            stg_r_en, stg_g_en;
  logic [CH_W-1:0] rdata_q, rdata_d;
  logic            rdata_en;

  always_comb begin
    addr_d   = addr_q;
    chan_d   = chan_q;
    seq_en   = 1'b0;
    stg_r_en = 1'b0;
    stg_g_en = 1'b0;
    commit   = 1'b0;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (addr_we) begin
      seq_en = 1'b1;
      addr_d = wdata[AW-1:0];
      chan_d = CH_RED;
    end else if (wr) begin
      seq_en = 1'b1;
      case (chan_q)
        CH_RED: begin
          stg_r_en = 1'b1;
          chan_d   = CH_GRN;
        end
        CH_GRN: begin
          stg_g_en = 1'b1;
          chan_d   = CH_BLU;
        end
        CH_BLU: begin
          commit = 1'b1;
          addr_d = addr_q + AW'(1);
          chan_d = CH_RED;
        end
        default: chan_d = CH_RED;
      endcase
    end else if (rd) begin
      seq_en   = 1'b1;
      rdata_en = 1'b1;
      case (chan_q)
        CH_RED: begin
          rdata_d = cur_entry[DW-1 -: CH_W];
          chan_d  = CH_GRN;
        end
        CH_GRN: begin
          rdata_d = cur_entry[2*CH_W-1 -: CH_W];
          chan_d  = CH_BLU;
        end
        CH_BLU: begin
          rdata_d = cur_entry[CH_W-1:0];
          addr_d  = addr_q + AW'(1);
          chan_d  = CH_RED;
        end
        default: chan_d = CH_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      chan_q  <= CH_RED;
      stg_r_q <= '0;
      stg_g_q <= '0;
      rdata_q <= '0;
    end else begin
      if (seq_en) begin
        addr_q <= addr_d;
        chan_q <= chan_d;
      end
      if (stg_r_en) stg_r_q <= wdata;
      if (stg_g_en) stg_g_q <= wdata;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign commit_data = {stg_r_q, stg_g_q, wdata};
  assign rdata       = rdata_q;
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage #(
  parameter int IN_W = 8,
  parameter int CH_W = 10,
  localparam int EXT = CH_W - IN_W,
  localparam int DW  = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3*IN_W-1:0] pix_in,
  input  logic              direct,
  input  logic [DW-1:0]     lut_entry,
  output logic [DW-1:0]     color_q
);
  logic [DW-1:0] wide;
  logic [DW-1:0] color_d;

  for (genvar c = 0; c < 3; c++) begin : g_lane
    logic [IN_W-1:0] lane;
    assign lane = pix_in[c*IN_W +: IN_W];
    // replicate the top bits into the new low bits so full scale stays full scale
    assign wide[c*CH_W +: CH_W] = {lane, lane[IN_W-1 -: EXT]};
  end

  always_comb begin
    color_d = direct ? wide : lut_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
    end else begin
      color_q <= color_d;
    end
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int IN_W    = pal_pkg::IN_W,
  parameter int CH_W    = pal_pkg::CH_W,
  parameter int DEPTH   = pal_pkg::DEPTH,
  localparam int AW     = $clog2(DEPTH),
  localparam int DW     = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3*IN_W-1:0] pix_in,
  input  logic              pix_direct,
  input  logic              host_addr_we,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [CH_W-1:0]   host_wdata,
  output logic [DW-1:0]     color_out,
  output logic [CH_W-1:0]   host_rdata
);
  logic [AW-1:0] addr_q;
  chan_e         chan_q;
  logic          commit;
  logic [DW-1:0] commit_data;
  logic [DW-1:0] lut_entry;
  logic [DW-1:0] host_entry;

  pal_host_port #(.CH_W(CH_W), .AW(AW)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_we     (host_addr_we),
    .wr          (host_wr),
    .rd          (host_rd),
    .wdata       (host_wdata),
    .cur_entry   (host_entry),
    .addr_q      (addr_q),
    .chan_q      (chan_q),
    .commit      (commit),
    .commit_data (commit_data),
    .rdata       (host_rdata)
  );

  pal_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk       (clk),
    .wr_en     (commit),
    .wr_addr   (addr_q),
    .wr_data   (commit_data),
    .pix_addr  (pix_in[AW-1:0]),
    .pix_data  (lut_entry),
    .host_addr (addr_q),
    .host_data (host_entry)
  );

  pal_out_stage #(.IN_W(IN_W), .CH_W(CH_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_in    (pix_in),
    .direct    (pix_direct),
    .lut_entry (lut_entry),
    .color_q   (color_out)
  );
endmodule

// File: rtl/pal_lookup_chk.sv
module pal_lookup_chk
  import pal_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int CH_W = 10,
  parameter int AW   = 8,
  localparam int EXT = CH_W - IN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*IN_W-1:0] pix_in,
  input logic              pix_direct,
  input logic              host_addr_we,
  input logic              host_wr,
  input logic              host_rd,
  input logic [CH_W-1:0]   host_wdata,
  input logic [3*CH_W-1:0] color_out,
  input logic [CH_W-1:0]   host_rdata,
  input logic [AW-1:0]     addr_q,
  input chan_e             chan_q
);
  logic [IN_W-1:0]   in_r, in_g, in_b;
  logic [3*CH_W-1:0] exp_wide;
  assign in_r = pix_in[3*IN_W-1 -: IN_W];
  assign in_g = pix_in[2*IN_W-1 -: IN_W];
  assign in_b = pix_in[IN_W-1:0];
  assign exp_wide = {in_r, in_r[IN_W-1 -: EXT], in_g, in_g[IN_W-1 -: EXT], in_b, in_b[IN_W-1 -: EXT]};

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (color_out == '0 && host_rdata == '0 && addr_q == '0 && chan_q == CH_RED));

  assert_direct_widen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_direct |=> color_out == $past(exp_wide));

  assert_hold_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr_we && chan_q != CH_BLU) |=> addr_q == $past(addr_q));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && !host_addr_we && chan_q == CH_BLU) |=> addr_q == $past(addr_q) + AW'(1));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr && !host_addr_we) |=> $stable(host_rdata));

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr_we |=> (addr_q == $past(host_wdata[AW-1:0]) && chan_q == CH_RED));
endmodule

bind pal_lookup pal_lookup_chk #(.IN_W(IN_W), .CH_W(CH_W), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_in       (pix_in),
  .pix_direct   (pix_direct),
  .host_addr_we (host_addr_we),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_wdata   (host_wdata),
  .color_out    (color_out),
  .host_rdata   (host_rdata),
  .addr_q       (addr_q),
  .chan_q       (chan_q)
);

// File: tb/pal_lookup_test.sv
`timescale 1ns/1ps
module pal_lookup_test;
  logic        clk;
  logic        rst_n;
  logic [23:0] pix_in;
  logic        pix_direct;
  logic        host_addr_we, host_wr, host_rd;
  logic [9:0]  host_wdata;
  logic [29:0] color_out;
  logic [9:0]  host_rdata;

  pal_lookup uut (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_direct(pix_direct),
    .host_addr_we(host_addr_we), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .color_out(color_out), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // behavioural reference
  int pal_r [256];
  int pal_g [256];
  int pal_b [256];
  int m_addr, m_ch, st_r, st_g;
  int exp_color, exp_rd;

  function automatic int widen8(input int c);
    return c * 4 + (c / 64);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_ch = 0; exp_color = 0; exp_rd = 0;
    end else begin
      int idx;
      idx = pix_in[7:0];
      if (pix_direct)
        exp_color = widen8(pix_in[23:16]) * 1048576 + widen8(pix_in[15:8]) * 1024 + widen8(pix_in[7:0]);
      else
        exp_color = pal_r[idx] * 1048576 + pal_g[idx] * 1024 + pal_b[idx];
      if (host_addr_we) begin
        m_addr = host_wdata[7:0]; m_ch = 0;
      end else if (host_wr) begin
        if (m_ch == 0) begin st_r = host_wdata; m_ch = 1; end
        else if (m_ch == 1) begin st_g = host_wdata; m_ch = 2; end
        else begin
          pal_r[m_addr] = st_r; pal_g[m_addr] = st_g; pal_b[m_addr] = host_wdata;
          m_addr = (m_addr + 1) % 256; m_ch = 0;
        end
      end else if (host_rd) begin
        if (m_ch == 0) begin exp_rd = pal_r[m_addr]; m_ch = 1; end
        else if (m_ch == 1) begin exp_rd = pal_g[m_addr]; m_ch = 2; end
        else begin exp_rd = pal_b[m_addr]; m_addr = (m_addr + 1) % 256; m_ch = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (color_out !== 30'(exp_color)) begin
        fails++;
        $display("FAIL %s color_out actual %h expected %h", tag, color_out, 30'(exp_color));
      end
      checks++;
      if (host_rdata !== 10'(exp_rd)) begin
        fails++;
        $display("FAIL %s host_rdata actual %h expected %h", tag, host_rdata, 10'(exp_rd));
      end
    end
  end

  task automatic step(input logic [23:0] p, input logic d, input logic aw,
                      input logic w, input logic r, input logic [9:0] wd);
    pix_in = p; pix_direct = d; host_addr_we = aw; host_wr = w; host_rd = r; host_wdata = wd;
    @(negedge clk);
  endtask

  task automatic idle_pix(input logic [23:0] p, input logic d);
    step(p, d, 1'b0, 1'b0, 1'b0, 10'd0);
  endtask

  initial begin
    rst_n = 1'b1;
    pix_in = '0; pix_direct = 1'b0; host_addr_we = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    #1 rst_n = 1'b0;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5/R6: fill from pointer 0 without loading it, 256 entries then wrap into entry 0
    tag = "R5";
    for (int i = 0; i < 256; i++) begin
      step(24'(i * 4099), 1'b1, 1'b0, 1'b1, 1'b0, 10'((i * 37 + 5) % 1024));
      step(24'(i * 7001), 1'b1, 1'b0, 1'b1, 1'b0, 10'((i * 91 + 300) % 1024));
      step(24'(i * 313),  1'b1, 1'b0, 1'b1, 1'b0, 10'((i * 523 + 17) % 1024));
    end
    tag = "R6";
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h3ff);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h155);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h2aa);
    idle_pix(24'h000000, 1'b0);
    idle_pix(24'h000001, 1'b0);

    // R2: every index through the palette with varied upper bits
    tag = "R2";
    for (int i = 0; i < 256; i++) idle_pix(24'((i * 65793 + 12345) & 24'hffff00) | 24'(i), 1'b0);

    // R3: direct path corner values
    tag = "R3";
    idle_pix(24'h000000, 1'b1);
    idle_pix(24'hffffff, 1'b1);
    idle_pix(24'h80407f, 1'b1);
    idle_pix(24'hc0013f, 1'b1);
    for (int i = 0; i < 40; i++) idle_pix(24'(i * 419431 + 77), 1'b1);

    // R4: select flips every pixel
    tag = "R4";
    for (int i = 0; i < 64; i++) idle_pix(24'(i * 262147 + 9), 1'(i % 2));
    for (int i = 0; i < 30; i++) idle_pix(24'(i * 99991), 1'((i / 3) % 2));

    // R5: partial write leaves entry 10 untouched until the blue write
    tag = "R5";
    step(24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd10);
    step(24'h00000a, 1'b0, 1'b0, 1'b1, 1'b0, 10'h001);
    step(24'h00000a, 1'b0, 1'b0, 1'b1, 1'b0, 10'h002);
    idle_pix(24'h00000a, 1'b0);
    idle_pix(24'h00000a, 1'b0);
    step(24'h00000a, 1'b0, 1'b0, 1'b1, 1'b0, 10'h003);
    idle_pix(24'h00000a, 1'b0);
    idle_pix(24'h00000b, 1'b0);

    // R8: commit and lookup of the same entry in one clock
    tag = "R8";
    step(24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd20);
    step(24'h000014, 1'b0, 1'b0, 1'b1, 1'b0, 10'h3a5);
    step(24'h000014, 1'b0, 1'b0, 1'b1, 1'b0, 10'h05a);
    step(24'h000014, 1'b0, 1'b0, 1'b1, 1'b0, 10'h1c3);
    idle_pix(24'h000014, 1'b0);
    idle_pix(24'h000014, 1'b0);

    // R7/R6: read back across the wrap point
    tag = "R7";
    step(24'h0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd254);
    for (int i = 0; i < 9; i++) begin
      step(24'(i), 1'b1, 1'b0, 1'b0, 1'b1, 10'd0);
      idle_pix(24'(i + 1), 1'b0);
    end

    // R9: pointer load beats write and read; write beats read
    tag = "R9";
    step(24'h0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd100);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h111);
    step(24'h0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd50);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h222);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h333);
    step(24'h0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h044);
    idle_pix(24'h000032, 1'b0);
    idle_pix(24'h000064, 1'b0);
    step(24'h0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd50);
    for (int i = 0; i < 3; i++) step(24'h0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd0);
    idle_pix(24'h0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule